// File: doc/BRIEF.md
# Workspace Context Switch Sequencer

This block performs the vectored context switch and its matching return for a 16-bit CPU whose general registers live in memory. The CPU keeps three registers on chip: the workspace pointer W, the program counter PC and the status word ST. Register n of the current workspace sits at byte address W + 2·n. All memory accesses are 16-bit words at even addresses.

A vectored switch does two reads and three writes. It reads a new W from the vector address and a new PC from the vector address + 2. It then writes the old W, PC and ST into registers 13, 14 and 15 of the new workspace. The old values are captured when the operation is accepted, so they are always the pre-switch context. The return takes no operand. It reads registers 13, 14 and 15 of the current workspace and loads W, PC and ST from them.

Reset has no load path of its own. When reset is released, the block runs a vectored switch through address 0. It then clears ST. Outside a switch, the surrounding core can load PC and ST directly.

Top module: `ctx_switch_seq`

## Requirements
- R1: After reset is released, the block runs a vectored switch without any start input. Its first two accesses are reads at byte address 0x0000 and then 0x0002.
- R2: A vectored switch makes exactly five accesses, in this order: a read at V, a read at V+2, then writes at W'+26, W'+28 and W'+30. Here V is the vector address and W' is the word read at V.
- R3: The three writes of a vectored switch carry the W, PC and ST held when the switch was accepted, in the order W, PC, ST. Afterwards W and PC hold the two vector words. ST is left unchanged.
- R4: A return makes three reads at W+26, W+28 and W+30, all using the W held when it started. It then loads W, PC and ST from those three words in that order.
- R5: An access holds mem_req, mem_addr, mem_we and mem_wdata steady until mem_ready is seen high. Each access is taken exactly once, whatever the wait length.
- R6: busy is high from the cycle after a start is accepted until the last access completes. done is high for exactly one cycle, in the cycle after the last access completes, and busy is low in that cycle.
- R7: While busy, start_blwp, start_rtwp, pc_ld and st_ld are ignored.
- R8: Reset does not clear W, PC or ST. The switch run after reset saves the values held before reset, and ST reads 0 once that switch completes.
- R9: If start_blwp and start_rtwp are high in the same idle cycle, the vectored switch is run.
- R10: Bit 0 of the vector address is ignored, so a vector at an odd address is read from the even address below it.
- R11: In an idle cycle, pc_ld loads pc_din into PC and st_ld loads st_din into ST, visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_blwp | input | 1 | Start a vectored context switch |
| start_rtwp | input | 1 | Start a context return |
| vec_addr | input | DW | Byte address of the two-word vector |
| pc_ld | input | 1 | Load PC from pc_din when idle |
| pc_din | input | DW | PC load value |
| st_ld | input | 1 | Load ST from st_din when idle |
| st_din | input | DW | ST load value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | DW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes in this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| w_out | output | DW | Current workspace pointer |
| pc_out | output | DW | Current program counter |
| st_out | output | DW | Current status word |

## Verification
The bench checks that a switch saves the context from before it was accepted. A design that latched too late would write the new W into register 13. It also checks that a return addresses all three reads with the original W, where an early update of W would read registers from the wrong workspace.

A second reset after PC and ST have been loaded shows that reset must not clear them and that ST is cleared only after it has been saved. Wait states on the memory side expose any access that is repeated or skipped. Start and load pulses during busy, and simultaneous start requests, would reveal a sequencer that restarts, corrupts PC or picks the return over the switch.

// File: rtl/ctx_switch_seq.sv
module ctx_switch_seq #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_blwp,
  input  logic          start_rtwp,
  input  logic [DW-1:0] vec_addr,
  input  logic          pc_ld,
  input  logic [DW-1:0] pc_din,
  input  logic          st_ld,
  input  logic [DW-1:0] st_din,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] w_out,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] st_out
);
  localparam logic [DW-1:0] OFS_R13 = DW'(26);
  localparam logic [DW-1:0] OFS_R14 = DW'(28);
  localparam logic [DW-1:0] OFS_R15 = DW'(30);
  localparam logic [DW-1:0] OFS_VPC = DW'(2);

  typedef enum logic [3:0] {IDLE, VW, VPC, S13, S14, S15, L13, L14, L15} seq_t;

  seq_t          state;
  logic          rst_go, from_rst;
  logic [DW-1:0] w, pc, st, vec, sv_w, sv_pc, sv_st;

  wire ack      = mem_req && mem_ready;
  wire go_blwp  = (state == IDLE) && (rst_go || start_blwp);
  wire go_rtwp  = (state == IDLE) && !rst_go && !start_blwp && start_rtwp;
  wire idle_ld  = (state == IDLE) && !rst_go && !start_blwp && !start_rtwp;

  assign mem_req = (state != IDLE);
  assign mem_we  = (state == S13) || (state == S14) || (state == S15);
  assign busy    = (state != IDLE) || rst_go;
  assign w_out   = w;
  assign pc_out  = pc;
  assign st_out  = st;

  always_comb begin
    case (state)
      VW:       mem_addr = vec;
      VPC:      mem_addr = vec + OFS_VPC;
      S13, L13: mem_addr = w + OFS_R13;
      S14, L14: mem_addr = w + OFS_R14;
      S15, L15: mem_addr = w + OFS_R15;
      default:  mem_addr = '0;
    endcase
  end

  always_comb begin
    case (state)
      S13:     mem_wdata = sv_w;
      S14:     mem_wdata = sv_pc;
      S15:     mem_wdata = sv_st;
      default: mem_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      rst_go   <= 1'b1;
      from_rst <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go_blwp) begin
        state    <= VW;
        from_rst <= rst_go;
        rst_go   <= 1'b0;
      end else if (go_rtwp) begin
        state <= L13;
      end else if (ack) begin
        case (state)
          VW:  state <= VPC;
          VPC: state <= S13;
          S13: state <= S14;
          S14: state <= S15;
          L13: state <= L14;
          L14: state <= L15;
          default: begin
            state <= IDLE;
            done  <= 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (go_blwp) begin
        vec   <= rst_go ? '0 : {vec_addr[DW-1:1], 1'b0};
        sv_w  <= w;
        sv_pc <= pc;
        sv_st <= st;
      end else if (idle_ld) begin
        if (pc_ld) pc <= pc_din;
        if (st_ld) st <= st_din;
      end else if (ack) begin
        case (state)
          VW:  w    <= mem_rdata;
          VPC: pc   <= mem_rdata;
          S15: if (from_rst) st <= '0;
          L13: sv_w <= mem_rdata;
          L14: pc   <= mem_rdata;
          L15: begin
            st <= mem_rdata;
            w  <= sv_w;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module ctx_switch_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] w_out
);
  wire [DW-1:0] rel = mem_addr - w_out;

  p_req_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_on_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));
  p_even_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);
  p_write_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (rel == DW'(26) || rel == DW'(28) || rel == DW'(30)));
endmodule

bind ctx_switch_seq ctx_switch_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .busy(busy), .done(done), .w_out(w_out)
);

// File: tb/test_ctx_switch_seq.sv
module test_ctx_switch_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_blwp = 0, start_rtwp = 0, pc_ld = 0, st_ld = 0;
  logic [15:0] vec_addr = 0, pc_din = 0, st_din = 0;
  logic mem_req, mem_we, mem_ready, busy, done;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, w_out, pc_out, st_out;

  logic [15:0] mem [0:255];
  logic [15:0] t_addr [0:15];
  logic [15:0] t_wd   [0:15];
  logic        t_we   [0:15];
  int t_n = 0, lat = 0, wcnt = 0, nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  ctx_switch_seq i_ctx_switch_seq (.*);

  assign mem_ready = mem_req && (wcnt >= lat);
  assign mem_rdata = mem[mem_addr[8:1]];

  always @(posedge clk) begin
    if (mem_req && !mem_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (mem_req && mem_ready) begin
      if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
      if (t_n < 16) begin
        t_addr[t_n] <= mem_addr; t_wd[t_n] <= mem_wdata; t_we[t_n] <= mem_we;
      end
      t_n <= t_n + 1;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) return;
    end
    check("R6 done timeout", 16'd0, 16'd1);
  endtask

  task automatic pulse_blwp(input logic [15:0] v);
    @(negedge clk); t_n = 0; vec_addr = v; start_blwp = 1;
    @(negedge clk); start_blwp = 0;
    check("R6 busy after start", {15'd0, busy}, 16'd1);
  endtask

  task automatic check_blwp_trace(input string req, input logic [15:0] v, input logic [15:0] nw,
                                  input logic [15:0] ow, input logic [15:0] opc, input logic [15:0] ost);
    check({req, " count"}, 16'(t_n), 16'd5);
    check({req, " vw addr"}, t_addr[0], v);
    check({req, " vw rd"}, {15'd0, t_we[0]}, 16'd0);
    check({req, " vpc addr"}, t_addr[1], v + 16'd2);
    check({req, " r13 addr"}, t_addr[2], nw + 16'd26);
    check({req, " r14 addr"}, t_addr[3], nw + 16'd28);
    check({req, " r15 addr"}, t_addr[4], nw + 16'd30);
    check({req, " r15 we"}, {15'd0, t_we[4]}, 16'd1);
    check("R3 saved W", t_wd[2], ow);
    check("R3 saved PC", t_wd[3], opc);
    check("R3 saved ST", t_wd[4], ost);
  endtask

  task automatic t_reset_vector();
    mem[0] = 16'h0100; mem[1] = 16'h0200;
    repeat (3) @(negedge clk);
    t_n = 0; rst_n = 1;
    check("R6 busy at reset release", {15'd0, busy}, 16'd1);
    wait_done();
    check("R6 busy low with done", {15'd0, busy}, 16'd0);
    check("R1 count", 16'(t_n), 16'd5);
    check("R1 first read addr", t_addr[0], 16'h0000);
    check("R1 second read addr", t_addr[1], 16'h0002);
    check("R1 r13 addr", t_addr[2], 16'h011A);
    check("R1 W", w_out, 16'h0100);
    check("R1 PC", pc_out, 16'h0200);
    check("R8 ST cleared", st_out, 16'h0000);
    @(negedge clk);
    check("R6 done one cycle", {15'd0, done}, 16'd0);
  endtask

  task automatic t_idle_load();
    @(negedge clk); pc_ld = 1; pc_din = 16'h0456; st_ld = 1; st_din = 16'hA5A5;
    @(negedge clk); pc_ld = 0; st_ld = 0;
    check("R11 PC load", pc_out, 16'h0456);
    check("R11 ST load", st_out, 16'hA5A5);
  endtask

  task automatic t_blwp();
    mem[8'h20] = 16'h0080; mem[8'h21] = 16'h0300;
    pulse_blwp(16'h0040);
    wait_done();
    check_blwp_trace("R2", 16'h0040, 16'h0080, 16'h0100, 16'h0456, 16'hA5A5);
    check("R3 new W", w_out, 16'h0080);
    check("R3 new PC", pc_out, 16'h0300);
    check("R3 ST kept", st_out, 16'hA5A5);
  endtask

  task automatic t_rtwp();
    @(negedge clk); t_n = 0; start_rtwp = 1;
    @(negedge clk); start_rtwp = 0;
    wait_done();
    check("R4 count", 16'(t_n), 16'd3);
    check("R4 r13 addr", t_addr[0], 16'h009A);
    check("R4 r14 addr", t_addr[1], 16'h009C);
    check("R4 r15 addr", t_addr[2], 16'h009E);
    check("R4 read", {15'd0, t_we[2]}, 16'd0);
    check("R4 W", w_out, 16'h0100);
    check("R4 PC", pc_out, 16'h0456);
    check("R4 ST", st_out, 16'hA5A5);
  endtask

  task automatic t_wait_states();
    lat = 3;
    pulse_blwp(16'h0041);
    wait_done();
    check_blwp_trace("R5", 16'h0040, 16'h0080, 16'h0100, 16'h0456, 16'hA5A5);
    check("R10 odd vector W", w_out, 16'h0080);
    lat = 0;
  endtask

  task automatic t_ignore_busy();
    pulse_blwp(16'h0040);
    start_rtwp = 1; pc_ld = 1; pc_din = 16'h7777; st_ld = 1; st_din = 16'h1111;
    start_blwp = 1; vec_addr = 16'h0000;
    @(negedge clk);
    start_rtwp = 0; pc_ld = 0; st_ld = 0; start_blwp = 0;
    wait_done();
    repeat (4) @(negedge clk);
    check("R7 no extra access", 16'(t_n), 16'd5);
    check("R7 vector kept", t_addr[0], 16'h0040);
    check("R7 PC untouched", pc_out, 16'h0300);
    check("R7 ST untouched", st_out, 16'hA5A5);
  endtask

  task automatic t_both_starts();
    @(negedge clk); t_n = 0; vec_addr = 16'h0040; start_blwp = 1; start_rtwp = 1;
    @(negedge clk); start_blwp = 0; start_rtwp = 0;
    wait_done();
    check("R9 count", 16'(t_n), 16'd5);
    check("R9 first is vector read", t_addr[0], 16'h0040);
    check("R9 first we", {15'd0, t_we[0]}, 16'd0);
  endtask

  task automatic t_reset_again();
    @(negedge clk); pc_ld = 1; pc_din = 16'h1234; st_ld = 1; st_din = 16'hBEEF;
    @(negedge clk); pc_ld = 0; st_ld = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    t_n = 0; rst_n = 1;
    wait_done();
    check_blwp_trace("R8", 16'h0000, 16'h0100, 16'h0080, 16'h1234, 16'hBEEF);
    check("R8 ST cleared after save", st_out, 16'h0000);
    check("R8 W", w_out, 16'h0100);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    t_reset_vector();
    t_idle_load();
    t_blwp();
    t_rtwp();
    t_wait_states();
    t_ignore_busy();
    t_both_starts();
    t_reset_again();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #2ms;
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule